// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block produces the Stop condition for an I2C master on an open-drain clock and data pair, and watches for a second master while it does so. A one-cycle request starts the sequence. The block first pulls the data line low. Once it sees data low, it lets the clock line go and waits for the clock to read high, which leaves room for a slave to hold the clock low. It then times a high period with a reloadable 8-bit down-counter, releases data, times a second period and reads the data line back.

Each pin is modelled as a pull-low enable, with a separate sampled input per line. Both inputs pass through a two-flop synchronizer before the sequencer uses them.

The sequence can end in one of two ways:
- **Success:** a stop-seen flag and a one-cycle done pulse.
- **Collision:** a sticky collision flag, with both lines released at once. The collision flag blocks further requests until a clear input is pulsed.

Top module: `i2c_stop_seq`

## Requirements
- R1: With the block idle and the collision flag clear, a one-cycle `stopReq` makes both `sdaDriveLow` and `sclDriveLow` read 1 (1 = pull the line low) after the next rising edge. A request made while a sequence is running has no effect.
- R2: `sclDriveLow` is released only after the synchronized data line reads low. `sdaIn` and `sclIn` pass through two flops, so a pin change first affects the sequencer at the third rising edge after the pin changes. With an unobstructed bus, `sclDriveLow` stays high for exactly 3 cycles.
- R3: After `sclDriveLow` is released, the block waits for as long as the synchronized clock reads low (a slave stretching the clock). This wait does not flag a collision.
- R4: Once the clock reads high, the counter is loaded with `reloadVal` and `sdaDriveLow` is released when the count reaches zero. With no stretching, `sdaDriveLow` stays high for `reloadVal`+4 cycles after `sclDriveLow` falls.
- R5: After data is released, a second count of max(`reloadVal`,2)+1 cycles runs. The data line is then read. If it reads high, `stopSeen` is set, `doneIrq` pulses for one cycle, both enables stay released and the collision flag stays clear.
- R6: If the data line reads low at the end of the second count, `collFlag` is set, both enables are released, the block returns to idle and neither `stopSeen` nor `doneIrq` is asserted.
- R7: If the clock reads low after it has been seen high, and before the data line has been seen high, `collFlag` is set and both enables are released at once.
- R8: `collFlag` stays set until `collClr` is pulsed. While it is set, `stopReq` is ignored and both enables stay released. Reset clears all flags and releases both lines.
- R9: `stopSeen` is cleared when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | One-cycle request to issue a Stop |
| collClr | input | 1 | Clears the sticky collision flag |
| reloadVal | input | 8 | Reload value for the bit-timing counter |
| sclIn | input | 1 | Sampled clock line level |
| sdaIn | input | 1 | Sampled data line level |
| sclDriveLow | output | 1 | 1 = pull the clock line low |
| sdaDriveLow | output | 1 | 1 = pull the data line low |
| stopSeen | output | 1 | Set by a completed Stop |
| collFlag | output | 1 | Sticky bus-collision flag |
| doneIrq | output | 1 | One-cycle pulse on a completed Stop |

## Verification
The hardest state to reach is a clock pulled low by another device after the sequencer has already seen the clock high, but before the data line has risen. From the ports, this looks exactly like the slave stretching the clock, which differs only in timing. The stimulus follows the reference model's own phase. It first holds the clock low right after release (a stretch, which must pass), and in a later run pulls the clock low three cycles into the timed high period (which must flag a collision). Data read-back after release is covered the same way, by holding data low only once the model has entered the release phase.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRV_SDA,
    ST_REL_SCL,
    ST_HOLD_HI,
    ST_REL_SDA
  } stop_state_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic cntLoad;    // load the bit-timing counter
    logic loadFloor;  // clamp the loaded value to the synchronizer depth
    logic cntHalt;    // stop the counter (abort)
  } ctrl_strobe_t;

  // status from datapath back to control
  typedef struct packed {
    logic sclSync;
    logic sdaSync;
    logic tick;
  } dp_status_t;

endpackage

// File: rtl/stop_seq_datapath.sv
module stop_seq_datapath
  import stop_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [CNT_W-1:0] reloadVal,
  input  ctrl_strobe_t     strobe,
  output dp_status_t       status
);

  localparam int LINES = 2;
  localparam logic [CNT_W-1:0] FLOOR_VAL = CNT_W'(SYNC_STAGES);

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] syncOut;

  assign rawIn = {sdaIn, sclIn};

  // per-line synchronizer chain, idle-high reset
  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = pipe[SYNC_STAGES-1];
  end

  // bit-timing down-counter
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic [CNT_W-1:0] loadVal;
  logic             tick;

  always_comb begin
    loadVal = reloadVal;
    if (strobe.loadFloor && (reloadVal < FLOOR_VAL)) loadVal = FLOOR_VAL;
  end

  assign tick = running && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (strobe.cntLoad) begin
      cnt     <= loadVal;
      running <= 1'b1;
    end else if (strobe.cntHalt) begin
      running <= 1'b0;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign status.sclSync = syncOut[0];
  assign status.sdaSync = syncOut[1];
  assign status.tick    = tick;

  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.cntLoad) |=> !tick);

endmodule

// File: rtl/stop_seq_ctrl.sv
module stop_seq_ctrl
  import stop_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         stopReq,
  input  logic         collClr,
  input  dp_status_t   stat,
  output ctrl_strobe_t strobe,
  output logic         sclDriveLow,
  output logic         sdaDriveLow,
  output logic         stopSeen,
  output logic         collFlag,
  output logic         doneIrq
);

  stop_state_e state, nextState;
  logic accept, setColl, setDone;

  always_comb begin
    nextState = state;
    strobe    = '0;
    accept    = 1'b0;
    setColl   = 1'b0;
    setDone   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (stopReq && !collFlag) begin
          accept    = 1'b1;
          nextState = ST_DRV_SDA;
        end
      end
      ST_DRV_SDA: begin
        if (!stat.sdaSync) nextState = ST_REL_SCL;
      end
      ST_REL_SCL: begin
        if (stat.sclSync) begin
          nextState      = ST_HOLD_HI;
          strobe.cntLoad = 1'b1;
        end
      end
      ST_HOLD_HI: begin
        if (!stat.sclSync) begin
          setColl        = 1'b1;
          strobe.cntHalt = 1'b1;
          nextState      = ST_IDLE;
        end else if (stat.tick) begin
          nextState        = ST_REL_SDA;
          strobe.cntLoad   = 1'b1;
          strobe.loadFloor = 1'b1;
        end
      end
      ST_REL_SDA: begin
        if (!stat.sclSync && !stat.sdaSync) begin
          setColl        = 1'b1;
          strobe.cntHalt = 1'b1;
          nextState      = ST_IDLE;
        end else if (stat.tick) begin
          nextState = ST_IDLE;
          if (!stat.sdaSync) setColl = 1'b1;
          else               setDone = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      collFlag <= 1'b0;
      stopSeen <= 1'b0;
      doneIrq  <= 1'b0;
    end else begin
      state   <= nextState;
      doneIrq <= setDone;
      if (setColl)      collFlag <= 1'b1;
      else if (collClr) collFlag <= 1'b0;
      if (accept)       stopSeen <= 1'b0;
      else if (setDone) stopSeen <= 1'b1;
    end
  end

  assign sclDriveLow = (state == ST_DRV_SDA);
  assign sdaDriveLow = (state == ST_DRV_SDA) || (state == ST_REL_SCL) ||
                       (state == ST_HOLD_HI);

  // R1
  accept_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && stopReq && !collFlag) |=> (sdaDriveLow && sclDriveLow));

  // R2
  scl_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclDriveLow) |-> $past(!stat.sdaSync));

  // R6 R7
  coll_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collFlag) |-> (!sclDriveLow && !sdaDriveLow && !stopSeen));

  // R8
  coll_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (collFlag && !collClr) |=> collFlag);

  // R8
  coll_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (collFlag && state == ST_IDLE) |=> (state == ST_IDLE));

  // R5
  done_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (stopSeen && !sclDriveLow && !sdaDriveLow && !collFlag));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
  import stop_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic             collClr,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             stopSeen,
  output logic             collFlag,
  output logic             doneIrq
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  stop_seq_datapath #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .reloadVal (reloadVal),
    .strobe    (strobe),
    .status    (status)
  );

  stop_seq_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .stopReq     (stopReq),
    .collClr     (collClr),
    .stat        (status),
    .strobe      (strobe),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .stopSeen    (stopSeen),
    .collFlag    (collFlag),
    .doneIrq     (doneIrq)
  );

endmodule

// File: tb/test_i2c_stop_seq.sv
module test_i2c_stop_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0, stopReq = 1'b0, collClr = 1'b0;
  logic [7:0] reloadVal = 8'd3;
  logic       extSclLow = 1'b0, extSdaLow = 1'b0;
  logic       sclIn, sdaIn;
  logic       sclDriveLow, sdaDriveLow, stopSeen, collFlag, doneIrq;

  // open-drain wired bus
  assign sclIn = !(sclDriveLow || extSclLow);
  assign sdaIn = !(sdaDriveLow || extSdaLow);

  i2c_stop_seq i_i2c_stop_seq (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .collClr(collClr),
    .reloadVal(reloadVal), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .stopSeen(stopSeen), .collFlag(collFlag), .doneIrq(doneIrq)
  );

  int compared = 0, mismatched = 0;

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 data low, 2 clock let go,
  // 3 timed high, 4 data let go
  int mPhase = 0;
  int mCnt = 0;
  bit mRun = 0, mColl = 0, mSeen = 0, mIrq = 0;
  bit sclHist[$];
  bit sdaHist[$];

  always @(posedge clk) begin
    bit sClk, sDat, tk, ld, flr, halt, accepted, coll, done;
    int lv;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mRun = 0; mColl = 0; mSeen = 0; mIrq = 0;
      sclHist = '{1'b1, 1'b1};
      sdaHist = '{1'b1, 1'b1};
    end else begin
      sClk = sclHist.pop_front();
      sDat = sdaHist.pop_front();
      sclHist.push_back(sclIn);
      sdaHist.push_back(sdaIn);
      tk = mRun && (mCnt == 0);
      ld = 0; flr = 0; halt = 0; accepted = 0; coll = 0; done = 0;
      if (mPhase == 0) begin
        if (stopReq && !mColl) begin accepted = 1; mPhase = 1; end
      end else if (mPhase == 1) begin
        if (!sDat) mPhase = 2;
      end else if (mPhase == 2) begin
        if (sClk) begin mPhase = 3; ld = 1; end
      end else if (mPhase == 3) begin
        if (!sClk) begin coll = 1; halt = 1; mPhase = 0; end
        else if (tk) begin mPhase = 4; ld = 1; flr = 1; end
      end else begin
        if (!sClk && !sDat) begin coll = 1; halt = 1; mPhase = 0; end
        else if (tk) begin
          mPhase = 0;
          if (!sDat) coll = 1; else done = 1;
        end
      end
      lv = int'(reloadVal);
      if (flr && lv < 2) lv = 2;
      if (ld) begin mCnt = lv; mRun = 1; end
      else if (halt) mRun = 0;
      else if (mRun) begin
        if (mCnt == 0) mRun = 0; else mCnt = mCnt - 1;
      end
      mIrq = done;
      if (coll) mColl = 1; else if (collClr) mColl = 0;
      if (accepted) mSeen = 0; else if (done) mSeen = 1;
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rstN) begin
      check("R1/R2 sclDriveLow", int'(sclDriveLow), int'(mPhase == 1));
      check("R4 sdaDriveLow", int'(sdaDriveLow), int'(mPhase >= 1 && mPhase <= 3));
      check("R8 collFlag", int'(collFlag), int'(mColl));
      check("R5 stopSeen", int'(stopSeen), int'(mSeen));
      check("R5 doneIrq", int'(doneIrq), int'(mIrq));
    end
  end

  task automatic pulseReq();
    @(negedge clk) stopReq = 1'b1;
    @(negedge clk) stopReq = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk) collClr = 1'b1;
    @(negedge clk) collClr = 1'b0;
  endtask

  task automatic waitPhase(int p);
    int guard = 0;
    while (mPhase != p && guard < 3000) begin @(negedge clk); guard++; end
    if (guard >= 3000) check("wait phase", mPhase, p);
  endtask

  task automatic checkIdle(string req, int expColl, int expSeen);
    check(req, int'(sclDriveLow), 0);
    check(req, int'(sdaDriveLow), 0);
    check(req, int'(collFlag), expColl);
    check(req, int'(stopSeen), expSeen);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int n, m;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R8 reset", 0, 0);

    // normal stop, timing of each step
    reloadVal = 8'd3;
    pulseReq();
    n = 0;
    while (sclDriveLow && n < 100) begin n++; @(negedge clk); end
    check("R2 scl hold cycles", n, 3);
    m = 0;
    while (sdaDriveLow && m < 1000) begin m++; @(negedge clk); end
    check("R4 sda hold after scl release", m, 3 + 4);
    waitPhase(0);
    @(negedge clk);
    checkIdle("R5 normal stop", 0, 1);

    // R9: accepted request clears stopSeen
    reloadVal = 8'd0;
    pulseReq();
    check("R9 stopSeen cleared", int'(stopSeen), 0);
    waitPhase(0);
    @(negedge clk);
    checkIdle("R5 reload 0 stop", 0, 1);

    // R3: slave stretches clock; extra request while busy (R1)
    reloadVal = 8'd5;
    pulseReq();
    waitPhase(2);
    extSclLow = 1'b1;
    repeat (12) @(negedge clk);
    check("R3 still waiting", int'(sdaDriveLow), 1);
    check("R3 no collision", int'(collFlag), 0);
    extSclLow = 1'b0;
    waitPhase(3);
    pulseReq();
    waitPhase(0);
    @(negedge clk);
    checkIdle("R3 stretched stop", 0, 1);

    // R6: other master holds data low after release
    reloadVal = 8'd4;
    pulseReq();
    waitPhase(4);
    extSdaLow = 1'b1;
    waitPhase(0);
    @(negedge clk);
    extSdaLow = 1'b0;
    checkIdle("R6 data collision", 1, 0);

    // R8: requests ignored while flag set
    pulseReq();
    repeat (10) @(negedge clk);
    checkIdle("R8 request ignored", 1, 0);
    pulseClr();
    check("R8 cleared", int'(collFlag), 0);

    // R7: clock pulled low during timed high period
    reloadVal = 8'd10;
    pulseReq();
    waitPhase(3);
    repeat (3) @(negedge clk);
    extSclLow = 1'b1;
    repeat (2) @(negedge clk);
    extSclLow = 1'b0;
    waitPhase(0);
    repeat (2) @(negedge clk);
    checkIdle("R7 clock collision", 1, 0);
    pulseClr();

    // long reload boundary
    reloadVal = 8'd255;
    pulseReq();
    waitPhase(0);
    @(negedge clk);
    checkIdle("R4 reload 255 stop", 0, 1);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule